// File: doc/BRIEF.md
# Power-management system-control register bank

This block holds the system-control registers of a power-management controller. It also runs the small sequences that hang off them. A host reaches it through a plain synchronous register bus: an address, write data, a write strobe, a read strobe and read data. Read data is combinational from the current register state. Any side effect of a read takes hold at the clock edge that ends the read cycle.

The block turns events into single-cycle request pulses for soft reset, power cycle and all-outputs-off. The events are a watchdog expiry pulse, a push-button input, an interrupt-source report, sleep entry, a guarded two-write shutdown command and a software power cycle. The software power cycle fires a fixed 8 ms after it is commanded, and that delay is counted in clock cycles from a clock-frequency parameter. Sticky flags record what happened so that software can collect them. The interrupt-source byte and the flags clear themselves when they are read.

Register map, 3-bit address: 0 watchdog control, 1 interrupt source, 2 button status, 3 shutdown/power-cycle control, 4 reset cause. Addresses 5 to 7 are unmapped.

Top module: `pwr_sysctl`

## Requirements
- R1: After reset the registers read as follows: address 0 reads 0x00, address 1 reads 0xFF, address 2 reads 0x00 with the button released, address 3 reads 0x00 and address 4 reads 0x00. Unmapped addresses 5 to 7 always read 0x00.
- R2: Watchdog control (address 0) stores bit 0, the power-cycle-on-expiry enable, and bit 1, the soft-reset-on-expiry enable. Bits 7:2 read 0 whatever was written.
- R3: A `wdog_expire` pulse sampled at an edge leads to one of these outcomes in the following cycle:
  - With only bit 1 of address 0 set, `srst_req` pulses for one cycle.
  - With bit 0 set, `pcyc_req` pulses for one cycle and `srst_req` stays 0. This holds whether or not bit 1 is also set.
  - With neither bit set, nothing happens.
- R4: `sleep_enter` clears both watchdog enables. It wins over a write to address 0 in the same cycle.
- R5: An `irq_src_valid` pulse loads `irq_src_id` into the interrupt-source byte (address 1). A read of address 1 returns the byte to 0xFF. A load in the same cycle as that read wins.
- R6: Bit 0 of button status (address 2) is the live button level, 1 while `btn_n` is low. It follows `btn_n` through a two-flop synchroniser.
- R7: Bit 1 of address 2 is set sticky on a press edge and bit 2 on a release edge. Both edges are detected on the synchronised level. A read of address 2 clears both bits, and a new edge in the same cycle wins over that clear.
- R8: Shutdown uses address 3.
  - Writing bit 0 = 1 with bit 1 = 0 arms the command; bit 0 reads back as the armed state.
  - A later write with bit 1 = 1 while armed pulses `all_off_req` for one cycle and disarms.
  - A write with bit 1 = 1 while not armed has no effect, even when bit 0 is set in the same write.
- R9: A write to address 3 with bit 1 = 0 and bit 0 = 0 disarms.
- R10: Writing bit 2 of address 3 starts the power-cycle delay.
  - `pcyc_req` pulses for one cycle exactly DELAY_CYC = CLK_FREQ_HZ/1e6*DELAY_US clock edges after the write edge.
  - Bit 2 reads 1 while the delay runs.
  - A start write while the delay is running is ignored.
- R11: The reset-cause register (address 4) works as follows:
  - Bit 0 is set by `srst_done` and bit 1 by `pcyc_done`.
  - A read of address 4 clears both bits, and a set in the same cycle wins over that clear.
- R12: Writes to addresses 1, 2 and 4 are ignored. Reads of addresses 0 and 3 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; side effects at the ending edge |
| reg_rdata | output | 8 | Combinational read data |
| sleep_enter | input | 1 | Sleep entry pulse |
| wdog_expire | input | 1 | Watchdog expiry pulse |
| btn_n | input | 1 | Active-low push-button, asynchronous |
| irq_src_valid | input | 1 | Interrupt source report strobe |
| irq_src_id | input | 8 | Address of the interrupting block |
| srst_done | input | 1 | Soft reset completed pulse |
| pcyc_done | input | 1 | Power cycle completed pulse |
| srst_req | output | 1 | Soft reset request pulse |
| pcyc_req | output | 1 | Power cycle request pulse |
| all_off_req | output | 1 | All-outputs-off request pulse |

## Verification
Most of the internal state is visible within one cycle. It shows either as a wrong value on a register read or as a request pulse that is present, missing or doubled in the cycle after the event that should cause it. The exception is the delay counter, whose off-by-one or reload errors only appear at the end of the delay as a pulse on the wrong edge. For that reason the bench counts edges from the start write to `pcyc_req`, including the case of a restart attempt in mid-count. Read-to-clear ordering errors show as a flag, or an interrupt-source value, that is lost or left stale on the read that follows.

// File: rtl/pwr_sysctl_pkg.sv
package pwr_sysctl_pkg;

    localparam int unsigned DATA_W = 8;

    // register addresses
    localparam int unsigned A_WDOG  = 0;
    localparam int unsigned A_IRQ   = 1;
    localparam int unsigned A_BTN   = 2;
    localparam int unsigned A_SHUT  = 3;
    localparam int unsigned A_CAUSE = 4;

    // watchdog control bits
    localparam int unsigned B_WD_PCYC = 0;
    localparam int unsigned B_WD_SRST = 1;
    // button status bits
    localparam int unsigned B_BTN_LIVE = 0;
    localparam int unsigned B_BTN_PRS  = 1;
    localparam int unsigned B_BTN_REL  = 2;
    // shutdown / power-cycle control bits
    localparam int unsigned B_SH_ARM   = 0;
    localparam int unsigned B_SH_OFF   = 1;
    localparam int unsigned B_SH_START = 2;
    // reset cause bits
    localparam int unsigned B_CS_SRST = 0;
    localparam int unsigned B_CS_PCYC = 1;

    localparam logic [DATA_W-1:0] IRQ_IDLE = 8'hFF;

    typedef struct packed {
        logic              wd_pcyc_en;
        logic              wd_srst_en;
        logic [DATA_W-1:0] irq_src;
        logic              prs_flag;
        logic              rel_flag;
        logic              armed;
        logic              srst_flag;
        logic              pcyc_flag;
        logic              srst_pulse;
        logic              wd_pcyc_pulse;
        logic              off_pulse;
    } ctrl_state_t;

endpackage

// File: rtl/btn_edge_sync.sv
module btn_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic level,
    output logic press,
    output logic release_ev
);

    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[SYNC_STAGES-1:0], ~btn_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level      = s_q.sh[SYNC_STAGES-1];
    assign press      = s_q.sh[SYNC_STAGES-1] & ~s_q.sh[SYNC_STAGES];
    assign release_ev = ~s_q.sh[SYNC_STAGES-1] & s_q.sh[SYNC_STAGES];

endmodule

// File: rtl/pcyc_delay_timer.sv
module pcyc_delay_timer #(
    parameter int unsigned DELAY_CYC = 2_000_000,
    localparam int unsigned CNT_W = $clog2(DELAY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_state_t;

    tmr_state_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
                t_d.done = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(DELAY_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
    assign done = t_q.done;

endmodule

// File: rtl/pwr_sysctl.sv
module pwr_sysctl
    import pwr_sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned CLK_FREQ_HZ = 250_000_000,
    parameter int unsigned DELAY_US    = 8000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sleep_enter,
    input  logic              wdog_expire,
    input  logic              btn_n,
    input  logic              irq_src_valid,
    input  logic [DATA_W-1:0] irq_src_id,
    input  logic              srst_done,
    input  logic              pcyc_done,
    output logic              srst_req,
    output logic              pcyc_req,
    output logic              all_off_req
);

    localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int unsigned DELAY_CYC  = (CYC_PER_US * DELAY_US < 1) ? 1 : CYC_PER_US * DELAY_US;

    ctrl_state_t c_d, c_q;

    logic btn_level, btn_press, btn_release;
    logic tmr_start, tmr_busy, tmr_done;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:3];

    btn_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_btn (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_n      (btn_n),
        .level      (btn_level),
        .press      (btn_press),
        .release_ev (btn_release)
    );

    pcyc_delay_timer #(
        .DELAY_CYC (DELAY_CYC)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned reg_a);
        return a == ADDR_W'(reg_a);
    endfunction

    logic wr_wdog, wr_shut, rd_irq, rd_btn, rd_cause;

    always_comb begin
        wr_wdog  = reg_wr && at(reg_addr, A_WDOG);
        wr_shut  = reg_wr && at(reg_addr, A_SHUT);
        rd_irq   = reg_rd && at(reg_addr, A_IRQ);
        rd_btn   = reg_rd && at(reg_addr, A_BTN);
        rd_cause = reg_rd && at(reg_addr, A_CAUSE);
    end

    assign tmr_start = wr_shut && reg_wdata[B_SH_START];

    always_comb begin
        c_d               = c_q;
        c_d.srst_pulse    = 1'b0;
        c_d.wd_pcyc_pulse = 1'b0;
        c_d.off_pulse     = 1'b0;

        // watchdog enables; sleep wins
        if (wr_wdog) begin
            c_d.wd_pcyc_en = reg_wdata[B_WD_PCYC];
            c_d.wd_srst_en = reg_wdata[B_WD_SRST];
        end
        if (sleep_enter) begin
            c_d.wd_pcyc_en = 1'b0;
            c_d.wd_srst_en = 1'b0;
        end

        // watchdog expiry; power cycle dominates soft reset
        if (wdog_expire) begin
            if (c_q.wd_pcyc_en)      c_d.wd_pcyc_pulse = 1'b1;
            else if (c_q.wd_srst_en) c_d.srst_pulse    = 1'b1;
        end

        // interrupt source byte; load wins over read-restore
        if (rd_irq)        c_d.irq_src = IRQ_IDLE;
        if (irq_src_valid) c_d.irq_src = irq_src_id;

        // button flags; edge wins over read-clear
        if (rd_btn) begin
            c_d.prs_flag = 1'b0;
            c_d.rel_flag = 1'b0;
        end
        if (btn_press)   c_d.prs_flag = 1'b1;
        if (btn_release) c_d.rel_flag = 1'b1;

        // two-write shutdown
        if (wr_shut) begin
            if (reg_wdata[B_SH_OFF]) begin
                if (c_q.armed) begin
                    c_d.off_pulse = 1'b1;
                    c_d.armed     = 1'b0;
                end
            end else begin
                c_d.armed = reg_wdata[B_SH_ARM];
            end
        end

        // reset cause flags; set wins over read-clear
        if (rd_cause) begin
            c_d.srst_flag = 1'b0;
            c_d.pcyc_flag = 1'b0;
        end
        if (srst_done) c_d.srst_flag = 1'b1;
        if (pcyc_done) c_d.pcyc_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.irq_src <= IRQ_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (at(reg_addr, A_WDOG)) begin
            reg_rdata[B_WD_PCYC] = c_q.wd_pcyc_en;
            reg_rdata[B_WD_SRST] = c_q.wd_srst_en;
        end else if (at(reg_addr, A_IRQ)) begin
            reg_rdata = c_q.irq_src;
        end else if (at(reg_addr, A_BTN)) begin
            reg_rdata[B_BTN_LIVE] = btn_level;
            reg_rdata[B_BTN_PRS]  = c_q.prs_flag;
            reg_rdata[B_BTN_REL]  = c_q.rel_flag;
        end else if (at(reg_addr, A_SHUT)) begin
            reg_rdata[B_SH_ARM]   = c_q.armed;
            reg_rdata[B_SH_START] = tmr_busy;
        end else if (at(reg_addr, A_CAUSE)) begin
            reg_rdata[B_CS_SRST] = c_q.srst_flag;
            reg_rdata[B_CS_PCYC] = c_q.pcyc_flag;
        end
    end

    assign srst_req    = c_q.srst_pulse;
    assign pcyc_req    = c_q.wd_pcyc_pulse | tmr_done;
    assign all_off_req = c_q.off_pulse;

endmodule

// File: rtl/pwr_sysctl_chk.sv
module pwr_sysctl_chk
    import pwr_sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              sleep_enter,
    input logic              wdog_expire,
    input logic              irq_src_valid,
    input logic              srst_req,
    input logic              pcyc_req,
    input logic              all_off_req
);

    // R2
    wdog_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(A_WDOG)) |-> (reg_rdata[DATA_W-1:2] == '0));

    // R3
    srst_from_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |-> $past(wdog_expire));

    // R3
    no_dual_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wdog_expire) && pcyc_req && $past(pcyc_req == 1'b0) |-> !srst_req);

    // R4
    sleep_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> (reg_addr != ADDR_W'(A_WDOG)) || (reg_rdata[1:0] == 2'b00));

    // R5
    irq_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(A_IRQ) && !irq_src_valid)
        |=> (reg_addr != ADDR_W'(A_IRQ)) || (reg_rdata == IRQ_IDLE));

    // R8
    off_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_off_req |-> $past(reg_wr && reg_addr == ADDR_W'(A_SHUT) && reg_wdata[B_SH_OFF]));

    // R8
    off_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_off_req |=> !all_off_req);

    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(A_CAUSE)) |-> (reg_rdata == '0));

endmodule

bind pwr_sysctl pwr_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_rdata     (reg_rdata),
    .sleep_enter   (sleep_enter),
    .wdog_expire   (wdog_expire),
    .irq_src_valid (irq_src_valid),
    .srst_req      (srst_req),
    .pcyc_req      (pcyc_req),
    .all_off_req   (all_off_req)
);

// File: tb/pwr_sysctl_bench.sv
module pwr_sysctl_bench;

    localparam int unsigned DELAY = 32;   // 4 MHz * 8 us

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       sleep_enter = 1'b0, wdog_expire = 1'b0, btn_n = 1'b1;
    logic       irq_src_valid = 1'b0;
    logic [7:0] irq_src_id = '0;
    logic       srst_done = 1'b0, pcyc_done = 1'b0;
    logic       srst_req, pcyc_req, all_off_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pwr_sysctl #(
        .ADDR_W      (3),
        .CLK_FREQ_HZ (4_000_000),
        .DELAY_US    (8),
        .SYNC_STAGES (2)
    ) u_pwr_sysctl (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_rdata (reg_rdata),
        .sleep_enter (sleep_enter), .wdog_expire (wdog_expire), .btn_n (btn_n),
        .irq_src_valid (irq_src_valid), .irq_src_id (irq_src_id),
        .srst_done (srst_done), .pcyc_done (pcyc_done),
        .srst_req (srst_req), .pcyc_req (pcyc_req), .all_off_req (all_off_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 check(tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expire(input string tag, input logic exp_srst, input logic exp_pcyc);
        @(negedge clk);
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
        check({tag, " srst"}, {7'd0, srst_req}, {7'd0, exp_srst});
        check({tag, " pcyc"}, {7'd0, pcyc_req}, {7'd0, exp_pcyc});
        @(negedge clk);
        check({tag, " srst end"}, {7'd0, srst_req}, 8'd0);
        check({tag, " pcyc end"}, {7'd0, pcyc_req}, 8'd0);
    endtask

    // {op, addr, wdata, expected}; op 0 = write, 1 = read and compare
    localparam int NVEC = 16;
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 8'hFF, 8'h00},  // R2 write all ones
        {1'b1, 3'd0, 8'h00, 8'h03},  // R2 reserved read 0
        {1'b0, 3'd0, 8'h02, 8'h00},  // R2
        {1'b1, 3'd0, 8'h00, 8'h02},  // R2 and R12 no side effect
        {1'b0, 3'd1, 8'h12, 8'h00},  // R12 write ignored
        {1'b1, 3'd1, 8'h00, 8'hFF},  // R12
        {1'b0, 3'd4, 8'h03, 8'h00},  // R12
        {1'b1, 3'd4, 8'h00, 8'h00},  // R12
        {1'b0, 3'd2, 8'h07, 8'h00},  // R12
        {1'b1, 3'd2, 8'h00, 8'h00},  // R12
        {1'b0, 3'd3, 8'h01, 8'h00},  // R8 arm
        {1'b1, 3'd3, 8'h00, 8'h01},  // R8 and R12
        {1'b0, 3'd3, 8'h00, 8'h00},  // R9 disarm
        {1'b1, 3'd3, 8'h00, 8'h00},  // R9
        {1'b1, 3'd5, 8'h00, 8'h00},  // R1 unmapped
        {1'b1, 3'd7, 8'h00, 8'h00}   // R1 unmapped
    };

    initial begin
        fork
            begin : tests
                repeat (3) @(negedge clk);
                rst_n = 1'b1;

                // R1 reset state
                rd("R1 wdog",  3'd0, 8'h00);
                rd("R1 irq",   3'd1, 8'hFF);
                rd("R1 btn",   3'd2, 8'h00);
                rd("R1 shut",  3'd3, 8'h00);
                rd("R1 cause", 3'd4, 8'h00);
                check("R1 outputs", {5'd0, srst_req, pcyc_req, all_off_req}, 8'd0);

                // register table
                for (int i = 0; i < NVEC; i++) begin
                    if (VEC[i][19] == 1'b0)
                        wr(VEC[i][18:16], VEC[i][15:8]);
                    else
                        rd($sformatf("table row %0d", i), VEC[i][18:16], VEC[i][7:0]);
                end

                // R3 expiry outcomes
                wr(3'd0, 8'h02); expire("R3 srst only", 1'b1, 1'b0);
                wr(3'd0, 8'h01); expire("R3 pcyc only", 1'b0, 1'b1);
                wr(3'd0, 8'h03); expire("R3 both", 1'b0, 1'b1);
                wr(3'd0, 8'h00); expire("R3 none", 1'b0, 1'b0);

                // R4 sleep clears, wins over same-cycle write
                wr(3'd0, 8'h03);
                @(negedge clk); sleep_enter = 1'b1;
                @(negedge clk); sleep_enter = 1'b0;
                rd("R4 sleep clear", 3'd0, 8'h00);
                @(negedge clk);
                reg_addr = 3'd0; reg_wdata = 8'h03; reg_wr = 1'b1; sleep_enter = 1'b1;
                @(negedge clk);
                reg_wr = 1'b0; sleep_enter = 1'b0;
                rd("R4 sleep wins", 3'd0, 8'h00);
                expire("R4 disabled", 1'b0, 1'b0);

                // R5 interrupt source
                @(negedge clk); irq_src_valid = 1'b1; irq_src_id = 8'h3C;
                @(negedge clk); irq_src_valid = 1'b0;
                rd("R5 loaded", 3'd1, 8'h3C);
                rd("R5 restored", 3'd1, 8'hFF);
                @(negedge clk);
                reg_addr = 3'd1; reg_rd = 1'b1; irq_src_valid = 1'b1; irq_src_id = 8'h55;
                #1 check("R5 old value", reg_rdata, 8'hFF);
                @(negedge clk);
                reg_rd = 1'b0; irq_src_valid = 1'b0;
                rd("R5 load wins", 3'd1, 8'h55);
                rd("R5 restored 2", 3'd1, 8'hFF);

                // R6 / R7 button
                @(negedge clk); btn_n = 1'b0;
                @(negedge clk);
                reg_addr = 3'd2;
                #1 check("R6 not through sync", reg_rdata, 8'h00);
                repeat (3) @(negedge clk);
                rd("R6 R7 press", 3'd2, 8'h03);
                rd("R7 press cleared", 3'd2, 8'h01);
                @(negedge clk); btn_n = 1'b1;
                repeat (4) @(negedge clk);
                rd("R7 release", 3'd2, 8'h04);
                rd("R7 release cleared", 3'd2, 8'h00);

                // R8 shutdown
                wr(3'd3, 8'h02);
                check("R8 unarmed off", {7'd0, all_off_req}, 8'd0);
                wr(3'd3, 8'h03);
                check("R8 arm+off unarmed", {7'd0, all_off_req}, 8'd0);
                rd("R8 still unarmed", 3'd3, 8'h00);
                wr(3'd3, 8'h01);
                wr(3'd3, 8'h02);
                check("R8 off pulse", {7'd0, all_off_req}, 8'd1);
                @(negedge clk);
                check("R8 pulse width", {7'd0, all_off_req}, 8'd0);
                rd("R8 disarmed", 3'd3, 8'h00);
                wr(3'd3, 8'h02);
                check("R8 second off", {7'd0, all_off_req}, 8'd0);

                // R9 arm then disarm, then off has no effect
                wr(3'd3, 8'h01);
                wr(3'd3, 8'h00);
                wr(3'd3, 8'h02);
                check("R9 off after disarm", {7'd0, all_off_req}, 8'd0);

                // R10 delayed power cycle with restart attempt
                begin
                    int k;
                    int seen;
                    wr(3'd3, 8'h04);
                    k = 0; seen = 0;
                    while (k < DELAY + 10 && seen == 0) begin
                        @(negedge clk);
                        k++;
                        reg_wr = 1'b0; reg_rd = 1'b0;
                        if (pcyc_req) seen = k;
                        if (k == 5) begin
                            reg_addr = 3'd3; reg_rd = 1'b1;
                            #1 check("R10 busy", reg_rdata, 8'h04);
                        end
                        if (k == 10) begin
                            reg_addr = 3'd3; reg_wdata = 8'h04; reg_wr = 1'b1;
                        end
                    end
                    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
                    check("R10 delay edges", 8'(seen), 8'(DELAY));
                    @(negedge clk);
                    check("R10 pulse width", {7'd0, pcyc_req}, 8'd0);
                    rd("R10 idle", 3'd3, 8'h00);
                end

                // R11 reset cause
                @(negedge clk); srst_done = 1'b1;
                @(negedge clk); srst_done = 1'b0;
                rd("R11 srst flag", 3'd4, 8'h01);
                rd("R11 cleared", 3'd4, 8'h00);
                @(negedge clk);
                reg_addr = 3'd4; reg_rd = 1'b1; pcyc_done = 1'b1;
                #1 check("R11 old value", reg_rdata, 8'h00);
                @(negedge clk);
                reg_rd = 1'b0; pcyc_done = 1'b0;
                rd("R11 set wins", 3'd4, 8'h02);
                rd("R11 cleared 2", 3'd4, 8'h00);
            end
            begin : watchdog
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule